// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the purely combinational integer execute stage of a small 32-bit load/store processor. It receives an operation select, two register operands, a 16-bit immediate, a 5-bit constant shift count and a flag that chooses the immediate as the second operand. It returns one 32-bit result in the same cycle. The block has no clock, no state and no flag outputs. A comparison reports its outcome only as the value 0 or 1 in the result word.

The operations are:
- wrapping add and subtract;
- the bitwise AND, OR, XOR and NOR, where a complement is obtained as NOR with a zero operand;
- left and right logical shifts and the right arithmetic shift, each by the constant count;
- signed and unsigned less-than tests.

Each operation widens the immediate by its own rule. Add, subtract and the signed compare sign-extend it. The logic operations and the unsigned compare zero-extend it.

Operation select encoding: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 SLL, 7 SRL, 8 SRA, 9 SLT, 10 SLTU. Codes 11 to 15 are unused.

Top module: `int_exec_unit`

## Requirements
- R1: With use_imm=0, op 0 returns opnd_a+opnd_b and op 1 returns opnd_a-opnd_b, both modulo 2^32 with no overflow indication.
- R2: With use_imm=1, ops 0 and 1 use the immediate sign-extended to 32 bits (bit 15 copied into bits 31:16) as the second operand.
- R3: Ops 2, 3 and 4 return the bitwise AND, OR and XOR of opnd_a with the second operand. With use_imm=1 the second operand is the immediate zero-extended (bits 31:16 are zero).
- R4: Op 5 returns ~(opnd_a | second operand), using the zero-extended immediate when use_imm=1. With a zero second operand the result is the complement of opnd_a.
- R5: Ops 6 and 7 shift opnd_a left and right by shamt (0 to 31), filling with zeros. opnd_b, imm and use_imm have no effect on shifts.
- R6: Op 8 shifts opnd_a right by shamt and fills the vacated bits with opnd_a[31].
- R7: Op 9 returns 1 when opnd_a is less than the second operand as two's-complement values, otherwise 0. With use_imm=1 the second operand is the sign-extended immediate. Result bits 31:1 are always zero.
- R8: Op 10 returns 1 when opnd_a is less than the second operand as unsigned values, otherwise 0. With use_imm=1 the second operand is the zero-extended immediate.
- R9: Op codes 11 to 15 return zero whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select, encoded as listed above |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| use_imm | input | 1 | 1 selects the widened immediate as second operand |
| result | output | 32 | Operation result |

## Verification
Every result is combinational, so it is due zero cycles after its stimulus. The bench changes the inputs on the falling edge of its 200 MHz clock. It compares the output one nanosecond later, well before the next rising edge, so each check sees a settled value for exactly the stimulus just applied. Random vectors over all sixteen select codes are mixed with directed cases:
- wrap-around at the signed and unsigned extremes;
- the immediate with bit 15 set, under each widening rule;
- shift counts of 0 and 31;
- NOR with zero.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam int XLEN    = 32;
  localparam int IMM_W   = 16;
  localparam int SHAMT_W = 5;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_SLT  = 4'd9,
    OP_SLTU = 4'd10
  } exec_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_NOR = 2'd3
  } bitwise_e;

  // Operations whose immediate is widened with its sign bit.
  function automatic logic op_wants_sext(logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
  endfunction

  // Operations that take the adder with an inverted second operand.
  function automatic logic op_wants_sub(logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

endpackage

// File: rtl/imm_widen.sv
module imm_widen
  import int_exec_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int IW = IMM_W
) (
  input  logic [IW-1:0] imm_in,
  input  logic          sext_en,
  output logic [DW-1:0] imm_out
);

  localparam int PAD = DW - IW;

  logic fill_bit;

  always_comb begin
    fill_bit = sext_en & imm_in[IW-1];
    imm_out  = {{PAD{fill_bit}}, imm_in};
  end

endmodule

// File: rtl/add_compare.sv
module add_compare #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic          subtract,
  output logic [DW-1:0] sum,
  output logic          less_signed,
  output logic          less_unsigned
);

  logic [DW-1:0] rhs_eff;
  logic [DW:0]   wide_sum;
  logic          carry_out;
  logic          sign_differs;

  always_comb begin
    rhs_eff   = rhs ^ {DW{subtract}};
    wide_sum  = {1'b0, lhs} + {1'b0, rhs_eff} + {{DW{1'b0}}, subtract};
    sum       = wide_sum[DW-1:0];
    carry_out = wide_sum[DW];
    // lhs - rhs borrows exactly when lhs < rhs unsigned.
    less_unsigned = ~carry_out;
    sign_differs  = lhs[DW-1] ^ rhs[DW-1];
    less_signed   = sign_differs ? lhs[DW-1] : sum[DW-1];
  end

endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit
  import int_exec_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  bitwise_e      func,
  output logic [DW-1:0] out
);

  logic [DW-1:0] or_val;

  always_comb begin
    or_val = lhs | rhs;
    unique case (func)
      BW_AND:  out = lhs & rhs;
      BW_OR:   out = or_val;
      BW_XOR:  out = lhs ^ rhs;
      BW_NOR:  out = ~or_val;
      default: out = '0;
    endcase
  end

endmodule

// File: rtl/barrel_shift.sv
module barrel_shift #(
  parameter int DW = 32,
  parameter int SW = 5
) (
  input  logic [DW-1:0] data_in,
  input  logic [SW-1:0] amount,
  input  logic          to_left,
  input  logic          arith,
  output logic [DW-1:0] data_out
);

  logic [DW-1:0] rev_in;
  logic [DW-1:0] stage [SW+1];
  logic [DW-1:0] rev_out;
  logic          fill;

  // Left shifts reuse the right-shifting network on a bit-reversed word.
  for (genvar b = 0; b < DW; b++) begin : g_rev
    assign rev_in[b]  = data_in[DW-1-b];
    assign rev_out[b] = stage[SW][DW-1-b];
  end

  assign fill     = arith & ~to_left & data_in[DW-1];
  assign stage[0] = to_left ? rev_in : data_in;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amount[s]
      ? {{STEP{fill}}, stage[s][DW-1:STEP]}
      : stage[s];
  end

  assign data_out = to_left ? rev_out : stage[SW];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
(
  input  logic [OP_W-1:0]    op_sel,
  input  logic [XLEN-1:0]    opnd_a,
  input  logic [XLEN-1:0]    opnd_b,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               use_imm,
  output logic [XLEN-1:0]    result
);

  localparam int HI_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_wide;
  logic [XLEN-1:0] opnd_second;
  logic [XLEN-1:0] arith_sum;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] bw_out;
  logic [XLEN-1:0] sh_out;
  bitwise_e        bw_func;
  logic            sext_en;
  logic            sub_en;
  logic            sh_left;
  logic            sh_arith;

  always_comb begin
    sext_en  = op_wants_sext(op_sel);
    sub_en   = op_wants_sub(op_sel);
    sh_left  = (op_sel == OP_SLL);
    sh_arith = (op_sel == OP_SRA);
    unique case (op_sel)
      OP_OR:   bw_func = BW_OR;
      OP_XOR:  bw_func = BW_XOR;
      OP_NOR:  bw_func = BW_NOR;
      default: bw_func = BW_AND;
    endcase
  end

  imm_widen #(.DW(XLEN), .IW(IMM_W)) u_widen (
    .imm_in  (imm),
    .sext_en (sext_en),
    .imm_out (imm_wide)
  );

  assign opnd_second = use_imm ? imm_wide : opnd_b;

  add_compare #(.DW(XLEN)) u_addcmp (
    .lhs           (opnd_a),
    .rhs           (opnd_second),
    .subtract      (sub_en),
    .sum           (arith_sum),
    .less_signed   (lt_s),
    .less_unsigned (lt_u)
  );

  bitwise_unit #(.DW(XLEN)) u_bitwise (
    .lhs  (opnd_a),
    .rhs  (opnd_second),
    .func (bw_func),
    .out  (bw_out)
  );

  barrel_shift #(.DW(XLEN), .SW(SHAMT_W)) u_shift (
    .data_in  (opnd_a),
    .amount   (shamt),
    .to_left  (sh_left),
    .arith    (sh_arith),
    .data_out (sh_out)
  );

  always_comb begin
    unique case (op_sel)
      OP_ADD, OP_SUB:                  result = arith_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:   result = bw_out;
      OP_SLL, OP_SRL, OP_SRA:          result = sh_out;
      OP_SLT:                          result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                         result = {{(XLEN-1){1'b0}}, lt_u};
      default:                         result = '0;
    endcase
  end

  always_comb begin
    if (use_imm && (op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_SLT)) begin
      // R2
      sext_upper_chk: assert (opnd_second[XLEN-1:IMM_W] == {HI_W{imm[IMM_W-1]}})
        else $error("immediate not sign-extended");
    end
    if (use_imm && (op_sel inside {OP_AND, OP_OR, OP_XOR, OP_NOR, OP_SLTU})) begin
      // R3
      zext_upper_chk: assert (opnd_second[XLEN-1:IMM_W] == '0)
        else $error("immediate not zero-extended");
    end
    if (op_sel == OP_SLT || op_sel == OP_SLTU) begin
      // R7
      cmp_bool_chk: assert (result[XLEN-1:1] == '0)
        else $error("compare result not 0/1");
    end
    if (op_sel > OP_SLTU) begin
      // R9
      unknown_zero_chk: assert (result == '0)
        else $error("unused op select gave nonzero result");
    end
    if ((op_sel == OP_SLL || op_sel == OP_SRL || op_sel == OP_SRA) && shamt == '0) begin
      // R5
      shift_zero_chk: assert (result == opnd_a)
        else $error("shift by zero changed operand");
    end
  end

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic        use_imm;
  logic [31:0] result;

  int  n_tests;
  int  n_fail;
  bit  done;

  int_exec_unit u_int_exec_unit (
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .imm     (imm),
    .shamt   (shamt),
    .use_imm (use_imm),
    .result  (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                       logic [15:0] im, logic [4:0] sh, logic ui);
    logic [31:0] sx;
    logic [31:0] zx;
    logic [31:0] y;
    sx = {{16{im[15]}}, im};
    zx = {16'h0, im};
    if (!ui)                             y = b;
    else if (op == 0 || op == 1 || op == 9) y = sx;
    else                                 y = zx;
    case (op)
      4'd0:  return a + y;
      4'd1:  return a - y;
      4'd2:  return a & y;
      4'd3:  return a | y;
      4'd4:  return a ^ y;
      4'd5:  return ~(a | y);
      4'd6:  return a << sh;
      4'd7:  return a >> sh;
      4'd8:  return $unsigned($signed(a) >>> sh);
      4'd9:  return {31'h0, ($signed(a) < $signed(y))};
      4'd10: return {31'h0, (a < y)};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] op, logic ui);
    case (op)
      4'd0, 4'd1: return ui ? "R2" : "R1";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input logic ui,
                       input string req);
    logic [31:0] exp;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm = im; shamt = sh; use_imm = ui;
    exp = model(op, a, b, im, sh, ui);
    #1;
    n_tests++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d ui=%0b actual=%h expected=%h",
               req, op, a, b, im, sh, ui, result, exp);
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_sel = '0; opnd_a = '0; opnd_b = '0; imm = '0; shamt = '0; use_imm = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Quiescent state after reset: ADD of zeros gives zero (R1)
    apply(4'd0, 32'h0, 32'h0, 16'h0, 5'd0, 1'b0, "R1");
    // R1 wrap-around
    apply(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R1");
    apply(4'd1, 32'h0, 32'h1, 16'h0, 5'd0, 1'b0, "R1");
    apply(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0, "R1");
    // R2 sign-extended immediate
    apply(4'd0, 32'h10, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R2");
    apply(4'd1, 32'h10, 32'h0, 16'h8000, 5'd0, 1'b1, "R2");
    // R3 zero-extended immediate
    apply(4'd2, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, 1'b1, "R3");
    apply(4'd3, 32'h0, 32'hFFFF_0000, 16'hFFFF, 5'd0, 1'b1, "R3");
    apply(4'd4, 32'hAAAA_AAAA, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R3");
    // R4 complement via NOR with zero
    apply(4'd5, 32'h1234_5678, 32'h0, 16'h0, 5'd0, 1'b0, "R4");
    apply(4'd5, 32'h0, 32'h0, 16'h8001, 5'd0, 1'b1, "R4");
    // R5 shifts, second operand ignored
    apply(4'd6, 32'h8000_0001, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 1'b1, "R5");
    apply(4'd7, 32'h8000_0000, 32'h1234, 16'h1, 5'd31, 1'b0, "R5");
    apply(4'd7, 32'hDEAD_BEEF, 32'h0, 16'h0, 5'd0, 1'b1, "R5");
    // R6 arithmetic fill
    apply(4'd8, 32'h8000_0000, 32'h0, 16'h0, 5'd31, 1'b0, "R6");
    apply(4'd8, 32'h4000_0000, 32'h0, 16'h0, 5'd30, 1'b0, "R6");
    // R7 signed compare
    apply(4'd9, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0, "R7");
    apply(4'd9, 32'h0, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R7");
    apply(4'd9, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R7");
    // R8 unsigned compare
    apply(4'd10, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0, "R8");
    apply(4'd10, 32'h0000_FFFE, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R8");
    apply(4'd10, 32'h0001_0000, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R8");
    // R9 unused selects
    for (int k = 11; k < 16; k++)
      apply(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd7, 1'(k & 1), "R9");
    // Random sweep
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op;
      logic        ui;
      op = 4'($urandom_range(15, 0));
      ui = 1'($urandom_range(1, 0));
      apply(op, $urandom(), $urandom(), 16'($urandom()), 5'($urandom()), ui, req_of(op, ui));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule